// File: doc/BRIEF.md
# Dual-Channel IDE I/O Address Decoder

This block sits between a host I/O access port and the task-file registers of two IDE channels. Each access arrives as an address, a size (byte, word or dword), a direction and write data. The block works out which channel and which register window the address falls in, and whether the access is one the channel honours. It then steers the access into a small per-channel register stub that stands in for the drive. Accesses that land in a window but are not honoured read back as all ones for their width, and are dropped when they are writes.

A write of the programming-interface byte picks the decoding mode through its low nibble. In native mode only the native base windows, fixed by parameters, decode. In legacy mode the block also answers at the fixed compatibility ports, and the native windows keep decoding. The interrupt-pin value the block reports tracks the mode.

Top module: `ide_io_decoder`

## Requirements
- R1: After reset the block is in native mode, `intPin` is 1, `rdValid` is 0, `devCtl` is 0 and every stub register, including the data latch, reads as 0.
- R2: A `cfgWrEn` cycle whose `cfgWrData[3:0]` is 4'hA selects legacy mode from the next clock edge onward; `intPin` then reads 0.
- R3: A `cfgWrEn` cycle whose `cfgWrData[3:0]` is 4'hF selects native mode from the next clock edge onward; `intPin` then reads 1 and the legacy ports no longer hit.
- R4: A `cfgWrEn` cycle with any other low nibble leaves the mode, `intPin` and the decoding unchanged.
- R5: The native windows decode in both modes: an 8-byte command window at `NAT_CMD_BASE[c]` and a 4-byte control window at `NAT_CTL_BASE[c]` for channel c.
- R6: In legacy mode channel 0 also answers at command ports 0x1F0..0x1F7 and control port 0x3F6, and channel 1 at 0x170..0x177 and 0x376; the control port acts as control-window offset 2.
- R7: A byte access (`ioSize`=0) at control-window offset 2 reads the channel's status register (command-window offset 7) and writes the channel's device-control register, visible on `devCtl[8c+7:8c]`.
- R8: Any other control-window access reads as all ones for its width (byte 0xFF, word 0xFFFF, dword 0xFFFFFFFF) and, as a write, changes nothing.
- R9: A byte access at command-window offset k reads or writes register k; offset 0 maps to the low byte of the channel's 32-bit data latch.
- R10: A word access (`ioSize`=1) at command-window offset 0 reads or writes data-latch bits 15:0; a dword access (`ioSize`=2 or 3) there reads or writes the whole latch. Channels keep separate state.
- R11: A word or dword access at a nonzero command-window offset reads as all ones for its width and, as a write, changes no register.
- R12: A read access that hits asserts `ioHit` in its own cycle and gives `rdValid`=1 with `rdData` one clock later; writes and accesses that hit nothing never raise `rdValid`, and a miss keeps `ioHit` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Programming-interface byte write strobe |
| cfgWrData | input | 8 | Programming-interface byte; low nibble selects the mode |
| ioValid | input | 1 | I/O access present this cycle |
| ioWrite | input | 1 | 1 = write, 0 = read |
| ioAddr | input | ADDR_W | I/O byte address |
| ioSize | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| ioWrData | input | DATA_W | Write data, low-aligned |
| ioHit | output | 1 | Access falls into an active window |
| rdValid | output | 1 | Read response valid |
| rdData | output | DATA_W | Read response data |
| intPin | output | 8 | Reported interrupt-pin value |
| devCtl | output | 8*IDE_CH | Device-control register of each channel |

## Verification
Three latencies matter: `ioHit` is combinational and is sampled one nanosecond after the access is driven, within the access cycle; `rdValid` and `rdData` come from a register and are sampled at the falling edge after the capturing rising edge; a mode change and every stub write are sampled at that same falling edge or later. The bench drives all inputs on falling edges, so each result has exactly one rising edge between stimulus and sample, and a separate scenario confirms that `rdValid` is still low before that edge and low again one cycle later, and that `intPin` has not yet moved while a mode write is still pending.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  localparam int IDE_CH = 2;
  localparam int CH_W = 1;
  localparam int TF_REGS = 7;   // command-window offsets 1..7
  localparam int STATUS_IDX = TF_REGS - 1;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  localparam logic [3:0] NIB_LEGACY = 4'hA;
  localparam logic [3:0] NIB_NATIVE = 4'hF;

  localparam logic [15:0] LEG_CMD0 = 16'h01F0;
  localparam logic [15:0] LEG_CMD1 = 16'h0170;
  localparam logic [15:0] LEG_CTL0 = 16'h03F6;
  localparam logic [15:0] LEG_CTL1 = 16'h0376;

  typedef struct packed {
    logic        fire;
    logic        wr;
    logic [CH_W-1:0] chan;
    logic [2:0]  off;
    logic        tfByte;
    logic        dataWord;
    logic        dataDword;
    logic        ctlByte;
    logic [31:0] onesMask;
  } ide_stb_t;

endpackage

// File: rtl/ide_dec_ctrl.sv
module ide_dec_ctrl
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [IDE_CH-1:0][ADDR_W-1:0] NAT_CMD_BASE = {16'hC010, 16'hC000},
  parameter logic [IDE_CH-1:0][ADDR_W-1:0] NAT_CTL_BASE = {16'hC018, 16'hC008}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  input  logic              ioValid,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [1:0]        ioSize,
  output ide_stb_t          stb,
  output logic              ioHit,
  output logic              legacyMode
);

  localparam logic [IDE_CH-1:0][ADDR_W-1:0] LEG_CMD =
    {ADDR_W'(LEG_CMD1), ADDR_W'(LEG_CMD0)};
  localparam logic [IDE_CH-1:0][ADDR_W-1:0] LEG_CTL =
    {ADDR_W'(LEG_CTL1), ADDR_W'(LEG_CTL0)};

  logic cfgUnused;
  assign cfgUnused = ^cfgWrData[7:4];

  // Mode register: only the two defined nibbles move it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      legacyMode <= 1'b0;
    end else if (cfgWrEn) begin
      if (cfgWrData[3:0] == NIB_LEGACY) legacyMode <= 1'b1;
      else if (cfgWrData[3:0] == NIB_NATIVE) legacyMode <= 1'b0;
    end
  end

  logic            cmdHit;
  logic            ctlHit;
  logic            ctlOffOk;
  logic [CH_W-1:0] chanSel;

  always_comb begin
    cmdHit   = 1'b0;
    ctlHit   = 1'b0;
    ctlOffOk = 1'b0;
    chanSel  = '0;
    for (int c = 0; c < IDE_CH; c++) begin
      if (ioAddr[ADDR_W-1:3] == NAT_CMD_BASE[c][ADDR_W-1:3] ||
          (legacyMode && ioAddr[ADDR_W-1:3] == LEG_CMD[c][ADDR_W-1:3])) begin
        cmdHit  = 1'b1;
        chanSel = CH_W'(c);
      end
      if (ioAddr[ADDR_W-1:2] == NAT_CTL_BASE[c][ADDR_W-1:2]) begin
        ctlHit   = 1'b1;
        ctlOffOk = (ioAddr[1:0] == 2'd2);
        chanSel  = CH_W'(c);
      end
      if (legacyMode && ioAddr == LEG_CTL[c]) begin
        ctlHit   = 1'b1;
        ctlOffOk = 1'b1;
        chanSel  = CH_W'(c);
      end
    end
  end

  logic isByte, isWord, isDword, offZero;
  assign isByte  = (ioSize == SZ_BYTE);
  assign isWord  = (ioSize == SZ_WORD);
  assign isDword = ioSize[1];
  assign offZero = (ioAddr[2:0] == 3'd0);

  assign ioHit = ioValid && (cmdHit || ctlHit);

  always_comb begin
    stb.fire      = ioHit;
    stb.wr        = ioWrite;
    stb.chan      = chanSel;
    stb.off       = ioAddr[2:0];
    stb.tfByte    = cmdHit && isByte;
    stb.dataWord  = cmdHit && isWord && offZero;
    stb.dataDword = cmdHit && isDword && offZero;
    stb.ctlByte   = ctlHit && ctlOffOk && isByte;
    stb.onesMask  = isDword ? 32'hFFFF_FFFF : (isWord ? 32'h0000_FFFF : 32'h0000_00FF);
  end

endmodule

// File: rtl/ide_dec_datapath.sv
module ide_dec_datapath
  import ide_dec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ide_stb_t            stb,
  input  logic [DATA_W-1:0]   ioWrData,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic [8*IDE_CH-1:0] devCtl
);

  logic [DATA_W-1:0] chRd [IDE_CH];

  for (genvar c = 0; c < IDE_CH; c++) begin : g_chan
    logic [DATA_W-1:0] dataLatch;
    logic [7:0]        tfReg [TF_REGS];
    logic [7:0]        devCtlR;
    logic              chWr;
    logic [2:0]        tfIdx;

    assign chWr  = stb.fire && stb.wr && (stb.chan == CH_W'(c));
    assign tfIdx = stb.off - 3'd1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataLatch <= '0;
        devCtlR   <= '0;
        for (int i = 0; i < TF_REGS; i++) tfReg[i] <= '0;
      end else if (chWr) begin
        if (stb.tfByte) begin
          if (stb.off == 3'd0) dataLatch[7:0] <= ioWrData[7:0];
          else                 tfReg[tfIdx] <= ioWrData[7:0];
        end
        if (stb.dataWord)  dataLatch[15:0] <= ioWrData[15:0];
        if (stb.dataDword) dataLatch <= ioWrData;
        if (stb.ctlByte)   devCtlR <= ioWrData[7:0];
      end
    end

    always_comb begin
      if (stb.tfByte)
        chRd[c] = (stb.off == 3'd0) ? DATA_W'(dataLatch[7:0]) : DATA_W'(tfReg[tfIdx]);
      else if (stb.dataWord)
        chRd[c] = DATA_W'(dataLatch[15:0]);
      else if (stb.dataDword)
        chRd[c] = dataLatch;
      else if (stb.ctlByte)
        chRd[c] = DATA_W'(tfReg[STATUS_IDX]);
      else
        chRd[c] = DATA_W'(stb.onesMask);
    end

    assign devCtl[8*c +: 8] = devCtlR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.fire && !stb.wr;
      rdData  <= (stb.fire && !stb.wr) ? chRd[stb.chan] : '0;
    end
  end

endmodule

// File: rtl/ide_io_decoder.sv
module ide_io_decoder
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [IDE_CH-1:0][ADDR_W-1:0] NAT_CMD_BASE = {16'hC010, 16'hC000},
  parameter logic [IDE_CH-1:0][ADDR_W-1:0] NAT_CTL_BASE = {16'hC018, 16'hC008}
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [7:0]          cfgWrData,
  input  logic                ioValid,
  input  logic                ioWrite,
  input  logic [ADDR_W-1:0]   ioAddr,
  input  logic [1:0]          ioSize,
  input  logic [DATA_W-1:0]   ioWrData,
  output logic                ioHit,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic [7:0]          intPin,
  output logic [8*IDE_CH-1:0] devCtl
);

  ide_stb_t stb;
  logic     legacyMode;

  ide_dec_ctrl #(
    .ADDR_W(ADDR_W),
    .NAT_CMD_BASE(NAT_CMD_BASE),
    .NAT_CTL_BASE(NAT_CTL_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr), .ioSize(ioSize),
    .stb(stb), .ioHit(ioHit), .legacyMode(legacyMode)
  );

  ide_dec_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ioWrData(ioWrData),
    .rdValid(rdValid), .rdData(rdData), .devCtl(devCtl)
  );

  assign intPin = legacyMode ? 8'd0 : 8'd1;

endmodule

// File: rtl/ide_io_decoder_chk.sv
module ide_io_decoder_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [7:0]        cfgWrData,
  input logic              ioValid,
  input logic              ioWrite,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioHit,
  input logic              rdValid,
  input logic [7:0]        intPin
);

  logic modeWr;
  assign modeWr = cfgWrEn && (cfgWrData[3:0] == 4'hA || cfgWrData[3:0] == 4'hF);

  p_legacy_pin_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && cfgWrData[3:0] == 4'hA |=> intPin == 8'd0);

  p_native_pin_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && cfgWrData[3:0] == 4'hF |=> intPin == 8'd1);

  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !modeWr |=> $stable(intPin));

  p_pin_values_r1: assert property (@(posedge clk) disable iff (!rstN)
    intPin == 8'd0 || intPin == 8'd1);

  p_no_legacy_native_r3: assert property (@(posedge clk) disable iff (!rstN)
    ioValid && intPin == 8'd1 && ioAddr == ADDR_W'(16'h01F0) |-> !ioHit);

  p_read_resp_r12: assert property (@(posedge clk) disable iff (!rstN)
    ioValid && !ioWrite && ioHit |=> rdValid);

  p_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(ioValid && !ioWrite && ioHit) |=> !rdValid);

endmodule

bind ide_io_decoder ide_io_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
  .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr),
  .ioHit(ioHit), .rdValid(rdValid), .intPin(intPin)
);

// File: tb/ide_io_decoder_test.sv
module ide_io_decoder_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [7:0]  cfgWrData;
  logic        ioValid;
  logic        ioWrite;
  logic [15:0] ioAddr;
  logic [1:0]  ioSize;
  logic [31:0] ioWrData;
  logic        ioHit;
  logic        rdValid;
  logic [31:0] rdData;
  logic [7:0]  intPin;
  logic [15:0] devCtl;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ide_io_decoder uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr), .ioSize(ioSize),
    .ioWrData(ioWrData), .ioHit(ioHit), .rdValid(rdValid), .rdData(rdData),
    .intPin(intPin), .devCtl(devCtl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ioRd(input logic [15:0] a, input logic [1:0] sz,
                      output logic hit, output logic vld, output logic [31:0] d);
    @(negedge clk);
    ioValid = 1'b1; ioWrite = 1'b0; ioAddr = a; ioSize = sz;
    #1 hit = ioHit;
    @(negedge clk);
    ioValid = 1'b0;
    vld = rdValid;
    d = rdData;
  endtask

  task automatic ioWr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    ioValid = 1'b1; ioWrite = 1'b1; ioAddr = a; ioSize = sz; ioWrData = d;
    @(negedge clk);
    ioValid = 1'b0; ioWrite = 1'b0;
  endtask

  task automatic cfg(input logic [7:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Read that must hit and return a value.
  task automatic rdExp(input string tag, input logic [15:0] a, input logic [1:0] sz,
                       input logic [31:0] exp);
    logic h, v;
    logic [31:0] d;
    ioRd(a, sz, h, v, d);
    chk({tag, " hit"}, 32'(h), 32'd1);
    chk({tag, " valid"}, 32'(v), 32'd1);
    chk({tag, " data"}, d, exp);
  endtask

  task automatic rdMiss(input string tag, input logic [15:0] a);
    logic h, v;
    logic [31:0] d;
    ioRd(a, 2'd0, h, v, d);
    chk({tag, " hit"}, 32'(h), 32'd0);
    chk({tag, " valid"}, 32'(v), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 intPin", 32'(intPin), 32'd1);
    chk("R1 devCtl", 32'(devCtl), 32'd0);
    chk("R1 rdValid", 32'(rdValid), 32'd0);
    rdExp("R1 data latch", 16'hC000, 2'd2, 32'd0);
    rdExp("R1 status ch1", 16'hC017, 2'd0, 32'd0);
  endtask

  task automatic t_native_regs;
    for (int k = 1; k < 8; k++) begin
      ioWr(16'hC000 + 16'(k), 2'd0, 32'h10 + 32'(k));
      ioWr(16'hC010 + 16'(k), 2'd0, 32'h80 + 32'(k));
    end
    for (int k = 1; k < 8; k++) begin
      rdExp("R9 R5 ch0 reg", 16'hC000 + 16'(k), 2'd0, 32'h10 + 32'(k));
      rdExp("R9 R5 ch1 reg", 16'hC010 + 16'(k), 2'd0, 32'h80 + 32'(k));
    end
  endtask

  task automatic t_data_port;
    ioWr(16'hC000, 2'd2, 32'hDEAD_BEEF);
    rdExp("R10 dword", 16'hC000, 2'd2, 32'hDEAD_BEEF);
    ioWr(16'hC000, 2'd1, 32'h5555_1234);
    rdExp("R10 word merge", 16'hC000, 2'd3, 32'hDEAD_1234);
    rdExp("R10 word read", 16'hC000, 2'd1, 32'h0000_1234);
    rdExp("R9 byte offset0", 16'hC000, 2'd0, 32'h34);
    rdExp("R10 ch1 separate", 16'hC010, 2'd2, 32'd0);
  endtask

  task automatic t_wide_offset;
    rdExp("R11 word off2", 16'hC002, 2'd1, 32'h0000_FFFF);
    rdExp("R11 dword off4", 16'hC004, 2'd2, 32'hFFFF_FFFF);
    ioWr(16'hC001, 2'd1, 32'h0000_AAAA);
    rdExp("R11 word write dropped", 16'hC001, 2'd0, 32'h11);
    ioWr(16'hC004, 2'd2, 32'h7777_7777);
    rdExp("R11 dword write dropped", 16'hC004, 2'd0, 32'h14);
    rdExp("R11 latch intact", 16'hC000, 2'd2, 32'hDEAD_1234);
  endtask

  task automatic t_control;
    rdExp("R7 alt status ch0", 16'hC00A, 2'd0, 32'h17);
    ioWr(16'hC00A, 2'd0, 32'h02);
    chk("R7 devctl ch0", 32'(devCtl), 32'h0002);
    rdExp("R8 ctl off1", 16'hC009, 2'd0, 32'hFF);
    rdExp("R8 ctl word", 16'hC00A, 2'd1, 32'hFFFF);
    rdExp("R8 ctl dword", 16'hC008, 2'd2, 32'hFFFF_FFFF);
    ioWr(16'hC00B, 2'd0, 32'h55);
    chk("R8 off3 write ignored", 32'(devCtl), 32'h0002);
    ioWr(16'hC00A, 2'd2, 32'hFFFF_FFFF);
    chk("R8 wide write ignored", 32'(devCtl), 32'h0002);
    ioWr(16'hC01A, 2'd0, 32'h04);
    chk("R7 devctl ch1", 32'(devCtl), 32'h0402);
    rdExp("R7 alt status ch1", 16'hC01A, 2'd0, 32'h87);
  endtask

  task automatic t_native_only;
    rdMiss("R3 no 1F0 native", 16'h01F0);
    rdMiss("R3 no 3F6 native", 16'h03F6);
    rdMiss("R12 unmapped", 16'h1234);
  endtask

  task automatic t_modes;
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = 8'h8A;
    #1 chk("R2 not before edge", 32'(intPin), 32'd1);
    @(negedge clk);
    cfgWrEn = 1'b0;
    chk("R2 intPin legacy", 32'(intPin), 32'd0);
    rdExp("R6 1F7 ch0", 16'h01F7, 2'd0, 32'h17);
    rdExp("R6 177 ch1", 16'h0177, 2'd0, 32'h87);
    rdExp("R6 3F6 alt status", 16'h03F6, 2'd0, 32'h17);
    rdExp("R6 1F0 dword", 16'h01F0, 2'd2, 32'hDEAD_1234);
    ioWr(16'h0376, 2'd0, 32'h06);
    chk("R6 376 devctl", 32'(devCtl), 32'h0602);
    rdExp("R8 3F6 word", 16'h03F6, 2'd1, 32'hFFFF);
    rdMiss("R6 3F7 not decoded", 16'h03F7);
    rdExp("R5 native in legacy", 16'hC011, 2'd0, 32'h81);
    cfg(8'hC5);
    chk("R4 nibble5 keeps legacy", 32'(intPin), 32'd0);
    rdExp("R4 legacy still hits", 16'h01F1, 2'd0, 32'h11);
    cfg(8'h0F);
    chk("R3 intPin native", 32'(intPin), 32'd1);
    rdMiss("R3 170 off", 16'h0170);
    rdMiss("R3 376 off", 16'h0376);
    cfg(8'hF0);
    chk("R4 nibble0 keeps native", 32'(intPin), 32'd1);
    rdMiss("R4 1F0 still off", 16'h01F0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    ioValid = 1'b1; ioWrite = 1'b0; ioAddr = 16'hC003; ioSize = 2'd0;
    #1 chk("R12 hit same cycle", 32'(ioHit), 32'd1);
    chk("R12 no early valid", 32'(rdValid), 32'd0);
    @(negedge clk);
    ioValid = 1'b1; ioWrite = 1'b1; ioAddr = 16'hC005; ioWrData = 32'h99;
    chk("R12 valid next cycle", 32'(rdValid), 32'd1);
    chk("R12 data next cycle", rdData, 32'h13);
    @(negedge clk);
    ioValid = 1'b0; ioWrite = 1'b0;
    chk("R12 write no valid", 32'(rdValid), 32'd0);
    rdExp("R9 back-to-back write", 16'hC005, 2'd0, 32'h99);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgWrData = '0;
    ioValid = 1'b0; ioWrite = 1'b0; ioAddr = '0; ioSize = '0; ioWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_native_regs();
    t_data_port();
    t_wide_offset();
    t_control();
    t_native_only();
    t_modes();
    t_timing();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule